// File: doc/BRIEF.md
# Full-Duplex PAUSE Flow Controller

This block makes the flow-control decisions of a 10 Mb/s full-duplex Ethernet MAC. On the receive side it watches the free byte count of the receive ring. When that count runs low, it asks the transmitter for one PAUSE frame with the longest pause time. Later the host moves its boundary pointer and enough room is back. The block then asks for a second PAUSE frame with a zero pause time, which lets the link partner resume.

On the transmit side it takes PAUSE frames that a receive path has already decoded. It holds back normal data frames for the time they request, counted in quanta of 512 bit times: 1024 cycles of the 20 MHz core clock. A pause that arrives while a frame is on the wire takes effect only when that frame ends. A zero pause ends the hold at once, and a newer pause restarts the count. The hold only gates data frames: a pending PAUSE request of the block's own is raised and kept regardless. With full duplex disabled the whole block is quiet.

Top module: `fdx_pause_ctrl`

## Requirements
- R1: With `fdx_en` high and the block armed, a sample of `free_space` strictly below LOW_MARK (default 3072) raises `pr_req` one clock later with `pr_time` = 16'hFFFF. A value equal to LOW_MARK raises nothing. The request stays up, with a steady time, until a clock where `pr_ack` is high.
- R2: A clock with `pr_req` and `pr_ack` both high drops `pr_req` on the next clock. No further low-space request follows while the space stays low.
- R3: After the low-space request is acknowledged, a `bdy_upd` pulse with `free_space` at or above RESUME_MARK (default 6144) raises `pr_req` one clock later with `pr_time` = 16'h0000. A `bdy_upd` pulse with less space does nothing. Once that request is acknowledged, the block is armed again for R1.
- R4: A `rxp_valid` pulse with `rxp_time` = n (n > 0), while `tx_busy` is low, raises `hold_data` on the next clock. `hold_data` then stays high for exactly n × 1024 clocks.
- R5: A pause that arrives while `tx_busy` is high and `tx_done` is low does not change `hold_data`. Its hold of n × 1024 clocks starts on the clock after the first cycle with `tx_done` high or `tx_busy` low.
- R6: A `rxp_valid` pulse with `rxp_time` = 0 while `tx_busy` is low drops `hold_data` on the next clock.
- R7: A new non-zero pause received during a hold restarts the count. `hold_data` then lasts exactly the new n × 1024 clocks from that pulse.
- R8: `hold_data` never blocks a PAUSE request: R1 and R3 behave the same while a hold is running.
- R9: With `fdx_en` low, `pr_req` and `hold_data` are low from the next clock on. Received pauses are ignored, and a deferred pause is dropped. Request tracking returns to the armed state, so a low-space sample after re-enabling raises a new R1 request.
- R10: While `rst` is high, and after it falls, `pr_req`, `pr_time` and `hold_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (20 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| fdx_en | input | 1 | Full-duplex mode enable |
| free_space | input | 16 | Free bytes in the receive ring |
| bdy_upd | input | 1 | One-clock pulse when the host advances the boundary pointer |
| rxp_valid | input | 1 | One-clock pulse when a valid PAUSE frame has been decoded |
| rxp_time | input | 16 | Pause time of that frame, in quanta |
| tx_busy | input | 1 | A frame is being transmitted |
| tx_done | input | 1 | One-clock pulse when the frame in flight ends |
| pr_ack | input | 1 | Transmitter takes the pending PAUSE request |
| pr_req | output | 1 | PAUSE frame requested |
| pr_time | output | 16 | Pause time to place in the requested frame |
| hold_data | output | 1 | Hold off normal data frames |

## Verification
Requests (R1, R3) and the end of a request after an acknowledge (R2) are due one clock after the input is sampled. The bench drives inputs one nanosecond after a rising edge and reads the outputs one nanosecond after the next rising edge. A hold (R4, R5, R7) starts one clock after the pulse, or after the `tx_done` clock, that applies it. The bench checks the start on that clock, then counts the clocks for which `hold_data` is seen high and compares the count with n × 1024. A zero pause (R6) and a mode disable (R9) are checked on the very next clock.

// File: rtl/fdx_pause_pkg.sv
`timescale 1ns/1ps
package fdx_pause_pkg;

    localparam int PT_W = 16;

    typedef logic [PT_W-1:0] ptime_t;

    localparam ptime_t PT_STOP  = 16'hFFFF;
    localparam ptime_t PT_RESUME = 16'h0000;

    typedef enum logic [1:0] {
        FC_ARMED,
        FC_STOP_REQ,
        FC_WAIT_ROOM,
        FC_RESUME_REQ
    } fc_state_e;

    typedef struct packed {
        logic   req;
        ptime_t qty;
    } pause_cmd_t;

    typedef struct packed {
        logic   go;
        ptime_t qty;
    } bo_load_t;

    function automatic pause_cmd_t cmd_for(fc_state_e s);
        pause_cmd_t c;
        c.req = 1'b0;
        c.qty = PT_RESUME;
        case (s)
            FC_STOP_REQ:   begin c.req = 1'b1; c.qty = PT_STOP;   end
            FC_RESUME_REQ: begin c.req = 1'b1; c.qty = PT_RESUME; end
            default:       begin c.req = 1'b0; c.qty = PT_RESUME; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fpc_xon_xoff.sv
`timescale 1ns/1ps
module fpc_xon_xoff
    import fdx_pause_pkg::*;
#(
    parameter int FREE_W      = 16,
    parameter int LOW_MARK    = 3072,
    parameter int RESUME_MARK = 6144
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [FREE_W-1:0] free_space,
    input  logic              bdy_upd,
    input  logic              ack,
    output pause_cmd_t        cmd
);

    localparam logic [FREE_W-1:0] LOW_LIM = FREE_W'(LOW_MARK);
    localparam logic [FREE_W-1:0] RES_LIM = FREE_W'(RESUME_MARK);

    fc_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            FC_ARMED:      if (free_space < LOW_LIM)              nxt = FC_STOP_REQ;
            FC_STOP_REQ:   if (ack)                               nxt = FC_WAIT_ROOM;
            FC_WAIT_ROOM:  if (bdy_upd && free_space >= RES_LIM)  nxt = FC_RESUME_REQ;
            FC_RESUME_REQ: if (ack)                               nxt = FC_ARMED;
            default:                                              nxt = FC_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) state <= FC_ARMED;
        else                state <= nxt;
    end

    assign cmd = cmd_for(state);

endmodule

// File: rtl/fpc_quanta_tick.sv
`timescale 1ns/1ps
module fpc_quanta_tick #(
    parameter int QUANT_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);

    localparam int PRE_W = (QUANT_CYC > 1) ? $clog2(QUANT_CYC) : 1;
    localparam logic [PRE_W-1:0] RELOAD = PRE_W'(QUANT_CYC - 1);

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt <= RELOAD;
        else if (cnt == '0)         cnt <= RELOAD;
        else                        cnt <= cnt - 1'b1;
    end

    assign tick = run && !restart && (cnt == '0);

endmodule

// File: rtl/fpc_backoff.sv
`timescale 1ns/1ps
module fpc_backoff
    import fdx_pause_pkg::*;
#(
    parameter int QUANT_CYC = 1024
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   rxp_valid,
    input  ptime_t rxp_time,
    input  logic   tx_busy,
    input  logic   tx_done,
    output logic   hold
);

    logic     defer;
    logic     pend;
    ptime_t   pend_time;
    bo_load_t ld;
    logic     active;
    ptime_t   qcnt;
    logic     tick;

    assign defer = tx_busy && !tx_done;

    always_comb begin
        ld.go  = 1'b0;
        ld.qty = rxp_time;
        if (enable && !defer) begin
            if (rxp_valid) begin
                ld.go  = 1'b1;
                ld.qty = rxp_time;
            end else if (pend) begin
                ld.go  = 1'b1;
                ld.qty = pend_time;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pend      <= 1'b0;
            pend_time <= '0;
        end else if (rxp_valid && defer) begin
            pend      <= 1'b1;
            pend_time <= rxp_time;
        end else if (!defer) begin
            pend      <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            active <= 1'b0;
            qcnt   <= '0;
        end else if (ld.go) begin
            active <= |ld.qty;
            qcnt   <= ld.qty;
        end else if (active && tick) begin
            if (qcnt == PT_W'(1)) active <= 1'b0;
            qcnt <= qcnt - 1'b1;
        end
    end

    fpc_quanta_tick #(.QUANT_CYC(QUANT_CYC)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (ld.go),
        .run     (active),
        .tick    (tick)
    );

    assign hold = active;

endmodule

// File: rtl/fdx_pause_ctrl.sv
`timescale 1ns/1ps
module fdx_pause_ctrl
    import fdx_pause_pkg::*;
#(
    parameter int FREE_W      = 16,
    parameter int LOW_MARK    = 3072,
    parameter int RESUME_MARK = 6144,
    parameter int QUANT_CYC   = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fdx_en,
    input  logic [FREE_W-1:0] free_space,
    input  logic              bdy_upd,
    input  logic              rxp_valid,
    input  logic [PT_W-1:0]   rxp_time,
    input  logic              tx_busy,
    input  logic              tx_done,
    input  logic              pr_ack,
    output logic              pr_req,
    output logic [PT_W-1:0]   pr_time,
    output logic              hold_data
);

    pause_cmd_t cmd;

    fpc_xon_xoff #(
        .FREE_W      (FREE_W),
        .LOW_MARK    (LOW_MARK),
        .RESUME_MARK (RESUME_MARK)
    ) u_req (
        .clk        (clk),
        .rst        (rst),
        .enable     (fdx_en),
        .free_space (free_space),
        .bdy_upd    (bdy_upd),
        .ack        (pr_ack),
        .cmd        (cmd)
    );

    fpc_backoff #(.QUANT_CYC(QUANT_CYC)) u_bo (
        .clk       (clk),
        .rst       (rst),
        .enable    (fdx_en),
        .rxp_valid (rxp_valid),
        .rxp_time  (rxp_time),
        .tx_busy   (tx_busy),
        .tx_done   (tx_done),
        .hold      (hold_data)
    );

    assign pr_req  = cmd.req;
    assign pr_time = cmd.qty;

endmodule

// File: rtl/fpc_checker.sv
`timescale 1ns/1ps
module fpc_checker #(
    parameter int FREE_W   = 16,
    parameter int LOW_MARK = 3072
) (
    input logic              clk,
    input logic              rst,
    input logic              fdx_en,
    input logic [FREE_W-1:0] free_space,
    input logic              rxp_valid,
    input logic [15:0]       rxp_time,
    input logic              tx_busy,
    input logic              tx_done,
    input logic              pr_ack,
    input logic              pr_req,
    input logic [15:0]       pr_time,
    input logic              hold_data
);

    // R1: a request waits, unchanged, for its acknowledge
    p_req_kept_r1: assert property (@(posedge clk) disable iff (rst)
        (fdx_en && pr_req && !pr_ack) |=> (pr_req && $stable(pr_time)));

    // R1: a stop request only follows a low free-space sample
    p_stop_cause_r1: assert property (@(posedge clk) disable iff (rst)
        ($rose(pr_req) && pr_time == 16'hFFFF) |-> ($past(free_space) < FREE_W'(LOW_MARK)));

    // R2: an acknowledge ends the request
    p_ack_drops_r2: assert property (@(posedge clk) disable iff (rst)
        (fdx_en && pr_req && pr_ack) |=> !pr_req);

    // R4: a non-zero pause with the transmitter idle starts a hold
    p_hold_start_r4: assert property (@(posedge clk) disable iff (rst)
        (fdx_en && rxp_valid && !tx_busy && rxp_time != 16'h0000) |=> hold_data);

    // R5: no hold starts while a frame is in flight
    p_defer_r5: assert property (@(posedge clk) disable iff (rst)
        (fdx_en && tx_busy && !tx_done && !hold_data) |=> !hold_data);

    // R6: a zero pause ends the hold
    p_zero_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (fdx_en && rxp_valid && !tx_busy && rxp_time == 16'h0000) |=> !hold_data);

    // R9: half duplex keeps the block quiet
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !fdx_en |=> (!pr_req && !hold_data));

endmodule

bind fdx_pause_ctrl fpc_checker #(
    .FREE_W   (FREE_W),
    .LOW_MARK (LOW_MARK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fdx_en     (fdx_en),
    .free_space (free_space),
    .rxp_valid  (rxp_valid),
    .rxp_time   (rxp_time),
    .tx_busy    (tx_busy),
    .tx_done    (tx_done),
    .pr_ack     (pr_ack),
    .pr_req     (pr_req),
    .pr_time    (pr_time),
    .hold_data  (hold_data)
);

// File: tb/sim_fdx_pause_ctrl.sv
`timescale 1ns/1ps
module sim_fdx_pause_ctrl;

    localparam int LOW  = 3072;
    localparam int HIGH = 6144;
    localparam int Q    = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fdx_en = 1'b0;
    logic [15:0] free_space = 16'd8000;
    logic        bdy_upd = 1'b0;
    logic        rxp_valid = 1'b0;
    logic [15:0] rxp_time = 16'h0;
    logic        tx_busy = 1'b0;
    logic        tx_done = 1'b0;
    logic        pr_ack = 1'b0;
    logic        pr_req;
    logic [15:0] pr_time;
    logic        hold_data;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fdx_pause_ctrl u0 (
        .clk(clk), .rst(rst), .fdx_en(fdx_en), .free_space(free_space),
        .bdy_upd(bdy_upd), .rxp_valid(rxp_valid), .rxp_time(rxp_time),
        .tx_busy(tx_busy), .tx_done(tx_done), .pr_ack(pr_ack),
        .pr_req(pr_req), .pr_time(pr_time), .hold_data(hold_data)
    );

    function automatic logic exp_stop(int f);
        return f < LOW;
    endfunction

    function automatic int exp_hold(int n);
        return n * Q;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ack_req();
        pr_ack = 1'b1;
        step();
        pr_ack = 1'b0;
    endtask

    task automatic send_pause(int n);
        rxp_valid = 1'b1;
        rxp_time  = 16'(n);
        step();
        rxp_valid = 1'b0;
    endtask

    task automatic measure(output int cnt);
        cnt = 0;
        while (hold_data && cnt < 100000) begin
            cnt++;
            step();
        end
    endtask

    initial begin
        int len;
        void'($urandom(32'h0000_5EED));
        step();
        chk("R10 pr_req in reset", pr_req, 0);
        chk("R10 hold in reset", hold_data, 0);
        rst = 1'b0;
        step();
        chk("R10 pr_req after reset", pr_req, 0);
        chk("R10 pr_time after reset", pr_time, 0);
        chk("R10 hold after reset", hold_data, 0);

        fdx_en = 1'b1;
        free_space = 16'(LOW);
        step();
        chk("R1 equal to mark", pr_req, 0);
        free_space = 16'(LOW - 1);
        step();
        chk("R1 stop raised", pr_req, 1);
        chk("R1 stop time", pr_time, 16'hFFFF);
        repeat (3) step();
        chk("R1 stop held", pr_req, 1);
        ack_req();
        chk("R2 dropped after ack", pr_req, 0);
        repeat (5) step();
        chk("R2 one stop per episode", pr_req, 0);

        free_space = 16'd5000;
        bdy_upd = 1'b1; step(); bdy_upd = 1'b0;
        chk("R3 too little room", pr_req, 0);
        free_space = 16'(HIGH);
        bdy_upd = 1'b1; step(); bdy_upd = 1'b0;
        chk("R3 resume raised", pr_req, 1);
        chk("R3 resume time", pr_time, 0);
        ack_req();
        chk("R3 resume acked", pr_req, 0);
        free_space = 16'd3000;
        step();
        chk("R3 rearmed stop", pr_req, 1);
        ack_req();
        free_space = 16'd8000;
        bdy_upd = 1'b1; step(); bdy_upd = 1'b0;
        ack_req();

        for (int i = 0; i < 16; i++) begin
            int f;
            f = int'($urandom_range(0, 8191));
            free_space = 16'(f);
            step();
            chk("R1 random watermark", pr_req, exp_stop(f));
            if (pr_req) begin
                ack_req();
                free_space = 16'd8000;
                bdy_upd = 1'b1; step(); bdy_upd = 1'b0;
                chk("R3 random resume", pr_req, 1);
                ack_req();
            end
        end
        free_space = 16'd8000;

        send_pause(2);
        chk("R4 hold starts", hold_data, 1);
        measure(len);
        chk("R4 hold length n=2", len, exp_hold(2));
        for (int i = 0; i < 4; i++) begin
            int n;
            n = int'($urandom_range(1, 5));
            send_pause(n);
            measure(len);
            chk("R4 random hold length", len, exp_hold(n));
            repeat (int'($urandom_range(1, 4))) step();
        end

        tx_busy = 1'b1;
        send_pause(3);
        chk("R5 deferred no hold", hold_data, 0);
        repeat (5) step();
        chk("R5 still deferred", hold_data, 0);
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
        tx_busy = 1'b0;
        chk("R5 hold after frame end", hold_data, 1);
        measure(len);
        chk("R5 deferred hold length", len, exp_hold(3));

        send_pause(10);
        repeat (100) step();
        send_pause(0);
        chk("R6 zero pause ends hold", hold_data, 0);

        send_pause(1);
        repeat (500) step();
        send_pause(2);
        measure(len);
        chk("R7 reload length", len, exp_hold(2));

        send_pause(5);
        free_space = 16'd1000;
        step();
        chk("R8 request during hold", pr_req, 1);
        chk("R8 hold still up", hold_data, 1);
        ack_req();
        send_pause(0);
        free_space = 16'd8000;
        bdy_upd = 1'b1; step(); bdy_upd = 1'b0;
        chk("R8 resume request", pr_req, 1);
        ack_req();

        fdx_en = 1'b0;
        send_pause(4);
        chk("R9 pause ignored", hold_data, 0);
        free_space = 16'd100;
        step();
        chk("R9 no request", pr_req, 0);
        fdx_en = 1'b1;
        step();
        chk("R9 rearmed after enable", pr_req, 1);
        ack_req();
        send_pause(4);
        chk("R9 hold before disable", hold_data, 1);
        fdx_en = 1'b0;
        step();
        chk("R9 hold cleared", hold_data, 0);
        free_space = 16'd8000;
        fdx_en = 1'b1;
        step();
        chk("R9 no stale hold", hold_data, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule